// File: doc/BRIEF.md
# SPI Master Word Engine

This block is the serial side of an SPI master. A register file elsewhere in the chip holds its settings and presents them as static levels: the SCK divisor, the clock polarity and phase, the bit order, the word length, the slave-select pattern, the trailing-clock controls and the single-wire mode controls. The same register file also presents four command levels: start, stop, read and write. Each start command, qualified by read and/or write, moves one word across the bus. The slave selects stay asserted from the first word until a stop command. The stop deselects the slaves, can add a few free-running SCK cycles, and then ends with a one-cycle completion strobe.

The register side clears start, read and write when it sees a rising edge on the read-done or write-done indication. It clears stop when it sees the completion strobe. There is no data stream with back-pressure here. The transmit byte is a level the engine copies when a word is launched. The received byte is a level that changes only at the end of a word that has the read command. The done indications hold until start is withdrawn, and in every case for at least two cycles, so that a slower clock domain can synchronise them.

Top module: `spi_word_engine`

## Requirements
- R1: The SCK half-period is `divisor_i` system clocks when `divisor_i` is 1 or more. A divisor of 0 behaves as 1.
- R2: `sck_o` equals `cpol_i` whenever no SCK cycle is in progress.
- R3: With `cpha_i`=0 the first data bit is on `mosi_o` before the first SCK edge and the slave samples on leading edges. With `cpha_i`=1 data changes on leading edges and is sampled on trailing edges.
- R4: With `lsb_first_i`=1 bit 0 is sent first, and the first received bit lands in bit 0. With `lsb_first_i`=0 bit `bit_ctl_i` is sent first, and the last received bit lands in bit 0.
- R5: A word is `bit_ctl_i`+1 bits long, so 3'b111 gives 8 bits. Received bits above the word length read as zero.
- R6: `ss_n_o` equals the inverse of `sel_pattern_i` from the launch of the first word until a stop command. It stays that way between words. Outside that span it is all ones.
- R7: A word with the read command loads `rx_byte_o` at its end. A word without it leaves `rx_byte_o` unchanged. A word without the write command drives `mosi_o` low.
- R8: At the end of a word, `rd_done_o` rises if read was commanded and `wr_done_o` rises if write was commanded. Each stays high for at least two cycles and until `start_i` falls.
- R9: A stop command while the slaves are selected deselects them. The engine then waits one half-period and pulses `xfer_done_o` for exactly one cycle. A stop command while nothing is selected has no effect.
- R10: After deselect, the engine emits `trail_cnt_i` full SCK cycles before the completion strobe when `trail_en_i`=1. It emits none when `trail_en_i`=0.
- R11: With `bidir_mode_i`=1 received bits come from `mosi_i` and `mosi_oe_o` follows `bidir_drive_i`. With `bidir_mode_i`=0 received bits come from `miso_i` and `mosi_oe_o` is 1.
- R12: While a word or its done phase is in progress, a held start command does not launch another word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor_i | input | 16 | SCK half-period in system clocks |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Sample on the second edge when 1 |
| lsb_first_i | input | 1 | Shift order select |
| bidir_mode_i | input | 1 | Single-wire mode |
| bidir_drive_i | input | 1 | Master drives the shared pin in single-wire mode |
| sel_pattern_i | input | 8 | One bit per slave to select |
| bit_ctl_i | input | 3 | Word length minus one |
| trail_en_i | input | 1 | Enables the SCK cycles after deselect |
| trail_cnt_i | input | 3 | Number of SCK cycles after deselect |
| start_i | input | 1 | Start command level |
| stop_i | input | 1 | Stop command level |
| read_i | input | 1 | Read command level |
| write_i | input | 1 | Write command level |
| tx_byte_i | input | 8 | Word to transmit |
| miso_i | input | 1 | Slave data in, normal mode |
| mosi_i | input | 1 | Shared data pin input, single-wire mode |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Master data out |
| mosi_oe_o | output | 1 | Output enable of the data-out pin |
| ss_n_o | output | 8 | Active-low slave selects |
| rx_byte_o | output | 8 | Last word received |
| rd_done_o | output | 1 | Read word finished |
| wr_done_o | output | 1 | Write word finished |
| xfer_done_o | output | 1 | One-cycle strobe when deselect is done |

## Verification
The assertions take for granted that the setting inputs do not change while a word, a deselect or trailing clocks are in progress. This matters most for the divisor, the word length and the phase, because the edge-spacing and done-width properties reason from them. The stimulus changes settings only while the engine is idle between words. It drops start, read and write after the first done edge, and drops stop after the completion strobe, as the register side does. It never raises start and stop together.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_HOLD  = 3'd2,
    ST_DESEL = 3'd3,
    ST_TRAIL = 3'd4
  } eng_state_t;
endpackage

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] n_eff;

  // A zero divisor is clamped to one half-period of one clock.
  assign n_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick  = run && (cnt == n_eff - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R1: with a half-period above one clock, ticks never come back to back
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n || !run)
    (tick && n_eff > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              lsb_first,
  input  logic [CNT_W-1:0]  bit_ctl,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              sample_bit,
  input  logic              capture,
  input  logic              op_rd,
  output logic              out_bit,
  output logic [DATA_W-1:0] rx_word
);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] rx_next;
  logic [DATA_W-1:0] word_mask;

  assign word_mask = {DATA_W{1'b1}} >> (TOP_IDX - bit_ctl);
  assign out_bit   = lsb_first ? tx_sr[0] : tx_sr[bit_ctl];

  always_comb begin
    rx_next = rx_sr;
    if (sample_en) begin
      if (lsb_first) begin
        rx_next          = rx_sr >> 1;
        rx_next[bit_ctl] = sample_bit;
      end else begin
        rx_next = {rx_sr[DATA_W-2:0], sample_bit};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_word <= '0;
    end else if (load) begin
      tx_sr <= tx_word;
      rx_sr <= '0;
    end else begin
      if (shift_en) begin
        tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      end
      rx_sr <= rx_next;
      if (capture && op_rd) begin
        rx_word <= rx_next & word_mask;
      end
    end
  end

  // R7: the received word only moves at the end of a read word
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && op_rd) |=> $stable(rx_word));

  // R3: shifting and sampling never fall on the same edge
  a_r3_edge_split: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !sample_en);
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int TRAIL_W = 3,
  parameter int EW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic               cmd_stop,
  input  logic               cmd_read,
  input  logic               cmd_write,
  input  logic               cpha,
  input  logic [CNT_W-1:0]   bit_ctl,
  input  logic               trail_en,
  input  logic [TRAIL_W-1:0] trail_cnt,
  input  logic               tick,
  output logic               run,
  output logic               load,
  output logic               shift_en,
  output logic               sample_en,
  output logic               capture,
  output logic               sck_ph,
  output logic               cs_active,
  output logic               op_rd,
  output logic               op_wr,
  output logic               rd_done,
  output logic               wr_done,
  output logic               xfer_done
);
  eng_state_t     state;
  logic [EW-1:0]  edge_cnt;
  logic [EW-1:0]  last_edge;
  logic [EW-1:0]  trail_last;
  logic           hold_seen;
  logic           launch;
  logic           in_shift;
  logic           samp_edge;

  // Word of W bits spans 2W edges; the last index is 2W-1.
  assign last_edge  = {{(EW-CNT_W-1){1'b0}}, bit_ctl, 1'b1};
  assign trail_last = {{(EW-TRAIL_W-1){1'b0}}, trail_cnt, 1'b0} - EW'(1);

  assign launch    = (state == ST_IDLE) && cmd_start && (cmd_read || cmd_write);
  assign load      = launch;
  assign run       = (state == ST_SHIFT) || (state == ST_DESEL) || (state == ST_TRAIL);
  // Leading edge when the phase bit is still at its idle value.
  assign samp_edge = (!sck_ph) ^ cpha;
  assign in_shift  = (state == ST_SHIFT) && tick;
  assign sample_en = in_shift && samp_edge;
  assign shift_en  = in_shift && !samp_edge && (edge_cnt != '0) && (edge_cnt != last_edge);
  assign capture   = in_shift && (edge_cnt == last_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      edge_cnt  <= '0;
      sck_ph    <= 1'b0;
      cs_active <= 1'b0;
      op_rd     <= 1'b0;
      op_wr     <= 1'b0;
      rd_done   <= 1'b0;
      wr_done   <= 1'b0;
      hold_seen <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            state     <= ST_SHIFT;
            cs_active <= 1'b1;
            op_rd     <= cmd_read;
            op_wr     <= cmd_write;
            edge_cnt  <= '0;
            sck_ph    <= 1'b0;
          end else if (cmd_stop && cs_active) begin
            state     <= ST_DESEL;
            cs_active <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sck_ph   <= ~sck_ph;
            edge_cnt <= edge_cnt + EW'(1);
            if (edge_cnt == last_edge) begin
              state     <= ST_HOLD;
              rd_done   <= op_rd;
              wr_done   <= op_wr;
              hold_seen <= 1'b0;
            end
          end
        end
        ST_HOLD: begin
          hold_seen <= 1'b1;
          if (hold_seen && !cmd_start) begin
            state   <= ST_IDLE;
            rd_done <= 1'b0;
            wr_done <= 1'b0;
          end
        end
        ST_DESEL: begin
          if (tick) begin
            if (trail_en && trail_cnt != '0) begin
              state    <= ST_TRAIL;
              edge_cnt <= '0;
              sck_ph   <= 1'b0;
            end else begin
              state     <= ST_IDLE;
              xfer_done <= 1'b1;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            sck_ph   <= ~sck_ph;
            edge_cnt <= edge_cnt + EW'(1);
            if (edge_cnt == trail_last) begin
              state     <= ST_IDLE;
              xfer_done <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: each done indication lasts at least two cycles
  a_r8_rd_done_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_done) |=> rd_done);
  a_r8_wr_done_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_done) |=> wr_done);
  // R9: the completion strobe is a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  // R6: shifting happens only with the slaves selected
  a_r6_cs_during_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) |-> cs_active);
  // R2: SCK sits at its idle phase between words and during deselect wait
  a_r2_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_HOLD || state == ST_DESEL) |-> !sck_ph);
  // R12: no launch while a done phase is still open
  a_r12_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && cmd_start) |=> !(state == ST_SHIFT));
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 8,
  parameter int DIV_W   = 16,
  parameter int TRAIL_W = 3,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   divisor_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               lsb_first_i,
  input  logic               bidir_mode_i,
  input  logic               bidir_drive_i,
  input  logic [SEL_W-1:0]   sel_pattern_i,
  input  logic [CNT_W-1:0]   bit_ctl_i,
  input  logic               trail_en_i,
  input  logic [TRAIL_W-1:0] trail_cnt_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               read_i,
  input  logic               write_i,
  input  logic [DATA_W-1:0]  tx_byte_i,
  input  logic               miso_i,
  input  logic               mosi_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               mosi_oe_o,
  output logic [SEL_W-1:0]   ss_n_o,
  output logic [DATA_W-1:0]  rx_byte_o,
  output logic               rd_done_o,
  output logic               wr_done_o,
  output logic               xfer_done_o
);
  localparam int EW = ((CNT_W > TRAIL_W) ? CNT_W : TRAIL_W) + 2;

  logic tick, run, load, shift_en, sample_en, capture;
  logic sck_ph, cs_active, op_rd, op_wr, out_bit, sample_bit;

  assign sample_bit = bidir_mode_i ? mosi_i : miso_i;

  spi_eng_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .divisor (divisor_i),
    .tick    (tick)
  );

  spi_eng_ctrl #(.CNT_W(CNT_W), .TRAIL_W(TRAIL_W), .EW(EW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (start_i),
    .cmd_stop  (stop_i),
    .cmd_read  (read_i),
    .cmd_write (write_i),
    .cpha      (cpha_i),
    .bit_ctl   (bit_ctl_i),
    .trail_en  (trail_en_i),
    .trail_cnt (trail_cnt_i),
    .tick      (tick),
    .run       (run),
    .load      (load),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .capture   (capture),
    .sck_ph    (sck_ph),
    .cs_active (cs_active),
    .op_rd     (op_rd),
    .op_wr     (op_wr),
    .rd_done   (rd_done_o),
    .wr_done   (wr_done_o),
    .xfer_done (xfer_done_o)
  );

  spi_eng_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .tx_word    (tx_byte_i),
    .lsb_first  (lsb_first_i),
    .bit_ctl    (bit_ctl_i),
    .shift_en   (shift_en),
    .sample_en  (sample_en),
    .sample_bit (sample_bit),
    .capture    (capture),
    .op_rd      (op_rd),
    .out_bit    (out_bit),
    .rx_word    (rx_byte_o)
  );

  assign sck_o     = cpol_i ^ sck_ph;
  assign mosi_o    = op_wr & out_bit;
  assign mosi_oe_o = bidir_mode_i ? bidir_drive_i : 1'b1;
  assign ss_n_o    = cs_active ? ~sel_pattern_i : {SEL_W{1'b1}};

  // R6: the completion strobe comes only with all slaves released
  a_r6_released_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> (ss_n_o == {SEL_W{1'b1}}));
  // R7: a word without write keeps the data line low while it shifts
  a_r7_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !op_wr && cs_active) |-> !mosi_o);
endmodule

// File: tb/spi_word_engine_tb.sv
module spi_word_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] divisor = 16'd2;
  logic cpol = 0, cpha = 0, lsb = 0, bidir = 0, bdrive = 0;
  logic [7:0] sel = 8'h04;
  logic [2:0] bit_ctl = 3'd7;
  logic trail_en = 0;
  logic [2:0] trail_cnt = 3'd0;
  logic start = 0, stop = 0, rd = 0, wr = 0;
  logic [7:0] tx_byte = 8'h00;
  logic miso, mosi_in;
  logic sck_o, mosi_o, mosi_oe_o, rd_done_o, wr_done_o, xfer_done_o;
  logic [7:0] ss_n_o, rx_byte_o;

  spi_word_engine u_dut (
    .clk(clk), .rst_n(rst_n), .divisor_i(divisor), .cpol_i(cpol), .cpha_i(cpha),
    .lsb_first_i(lsb), .bidir_mode_i(bidir), .bidir_drive_i(bdrive),
    .sel_pattern_i(sel), .bit_ctl_i(bit_ctl), .trail_en_i(trail_en),
    .trail_cnt_i(trail_cnt), .start_i(start), .stop_i(stop), .read_i(rd),
    .write_i(wr), .tx_byte_i(tx_byte), .miso_i(miso), .mosi_i(mosi_in),
    .sck_o(sck_o), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .ss_n_o(ss_n_o),
    .rx_byte_o(rx_byte_o), .rd_done_o(rd_done_o), .wr_done_o(wr_done_o),
    .xfer_done_o(xfer_done_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_edge_cyc = 0;
  int gap = 0;
  int sck_edges = 0;
  int trail_edges = 0;
  int sidx = 0;
  int xfer_cnt = 0;
  int done_len = 0;
  bit done_prev = 0;
  logic [7:0] slave_word = 8'h00;
  logic [7:0] slave_cap = 8'h00;
  logic [7:0] last_rx = 8'h00;
  logic sbit;
  logic [7:0] exp_rx_q[$];
  logic [7:0] exp_tx_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wlen();
    return int'(bit_ctl) + 1;
  endfunction

  // Slave model: bit index advances on every sampling edge.
  always @* begin
    if (sidx < wlen()) sbit = slave_word[lsb ? sidx : wlen() - 1 - sidx];
    else sbit = 1'b0;
  end
  assign miso    = bidir ? ~sbit : sbit;
  assign mosi_in = bidir ? sbit : ~sbit;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(sck_o) begin
    if (rst_n) begin
      gap = cyc - last_edge_cyc;
      last_edge_cyc = cyc;
      sck_edges++;
      if (ss_n_o == 8'hFF) begin
        trail_edges++;
      end else if (((sck_o != cpol) ? 1'b1 : 1'b0) ^ cpha) begin
        if (sidx < wlen()) slave_cap[lsb ? sidx : wlen() - 1 - sidx] = mosi_o;
        sidx++;
      end
    end
  end

  // Monitor: compares results against the scoreboard on each done rise.
  always @(negedge clk) begin
    bit done_now;
    logic [7:0] er, et;
    done_now = rd_done_o | wr_done_o;
    if (xfer_done_o) xfer_cnt++;
    if (done_now && !done_prev) begin
      done_len = 1;
      if (exp_rx_q.size() == 0) begin
        chk(0, "R8 unexpected done", 1, 0);
      end else begin
        er = exp_rx_q.pop_front();
        et = exp_tx_q.pop_front();
        chk(rx_byte_o == er, "R4/R5/R7 rx_byte", rx_byte_o, er);
        chk(slave_cap == et, "R3/R4/R7 mosi word", slave_cap, et);
      end
    end else if (done_now) begin
      done_len++;
    end else if (done_prev) begin
      chk(done_len >= 2, "R8 done width", done_len, 2);
    end
    done_prev = done_now;
  end

  task automatic run_word(input logic [7:0] tx, input logic [7:0] sw,
                          input bit r, input bit w, input bit hold_extra);
    logic [7:0] mask;
    int exp_gap;
    int edges_before;
    @(negedge clk);
    mask = 8'hFF >> (7 - int'(bit_ctl));
    exp_gap = (divisor == 0) ? 1 : int'(divisor);
    tx_byte = tx;
    slave_word = sw;
    sidx = 0;
    slave_cap = 8'h00;
    if (r) last_rx = sw & mask;
    exp_rx_q.push_back(last_rx);
    exp_tx_q.push_back(w ? (tx & mask) : 8'h00);
    start = 1; rd = r; wr = w;
    do @(negedge clk); while (!(rd_done_o || wr_done_o));
    chk(rd_done_o == r && wr_done_o == w, "R8 done select", {rd_done_o, wr_done_o}, {r, w});
    chk(ss_n_o == ~sel, "R6 select held", ss_n_o, ~sel);
    chk(gap == exp_gap, "R1 half period", gap, exp_gap);
    if (hold_extra) begin
      edges_before = sck_edges;
      repeat (6) @(negedge clk);
      chk(sck_edges == edges_before, "R12 no relaunch", sck_edges, edges_before);
      chk(rd_done_o | wr_done_o, "R8 done held with start", 0, 1);
    end
    start = 0; rd = 0; wr = 0;
    while (rd_done_o || wr_done_o) @(negedge clk);
    chk(sck_o == cpol, "R2 idle level", sck_o, cpol);
  endtask

  task automatic do_stop(input int exp_cycles);
    trail_edges = 0;
    @(negedge clk);
    stop = 1;
    do @(negedge clk); while (!xfer_done_o);
    chk(ss_n_o == 8'hFF, "R6 released", ss_n_o, 8'hFF);
    chk(trail_edges == 2 * exp_cycles, "R10 trailing edges", trail_edges, 2 * exp_cycles);
    stop = 0;
    @(negedge clk);
    chk(xfer_done_o == 1'b0, "R9 strobe width", xfer_done_o, 0);
    chk(sck_o == cpol, "R2 idle after stop", sck_o, cpol);
  endtask

  initial begin
    int xb;
    repeat (3) @(negedge clk);
    chk(sck_o == 0 && ss_n_o == 8'hFF && rx_byte_o == 0 && !rd_done_o && !wr_done_o
        && !xfer_done_o, "R2/R6 reset state", {sck_o, ss_n_o}, 9'h0FF);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(mosi_oe_o == 1'b1, "R11 normal drive", mosi_oe_o, 1);

    // Mode 0, MSB first, two words under one select
    run_word(8'hB4, 8'h1D, 1, 1, 0);
    run_word(8'h6E, 8'hC1, 1, 1, 0);
    chk(ss_n_o == ~sel, "R6 held between words", ss_n_o, ~sel);
    do_stop(0);

    // Stop with nothing selected is ignored
    xb = xfer_cnt;
    stop = 1;
    repeat (30) @(negedge clk);
    stop = 0;
    chk(xfer_cnt == xb && ss_n_o == 8'hFF, "R9 idle stop ignored", xfer_cnt, xb);

    // Mode 3, LSB first, divisor 3
    cpol = 1; cpha = 1; lsb = 1; divisor = 16'd3; sel = 8'h81;
    @(negedge clk);
    chk(sck_o == 1'b1, "R2 idle follows cpol", sck_o, 1);
    run_word(8'h2B, 8'h94, 1, 1, 0);

    // Mode 1, 5-bit words, divisor 0 acts as 1
    cpol = 0; lsb = 0; bit_ctl = 3'd4; divisor = 16'd0;
    run_word(8'hF3, 8'h0B, 1, 1, 0);
    // Read only: line stays low; write only: rx unchanged
    run_word(8'hFF, 8'h16, 1, 0, 0);
    run_word(8'h09, 8'h1F, 0, 1, 0);
    trail_en = 1; trail_cnt = 3'd3;
    do_stop(3);

    // Single-wire read, held start, trailing enable with zero count
    bidir = 1; bdrive = 0; bit_ctl = 3'd7; cpha = 0; divisor = 16'd1; sel = 8'h10;
    @(negedge clk);
    chk(mosi_oe_o == 1'b0, "R11 single wire released", mosi_oe_o, 0);
    run_word(8'h00, 8'h5C, 1, 0, 1);
    trail_cnt = 3'd0;
    do_stop(0);

    // Trailing count ignored when disabled
    bidir = 0; trail_en = 0; trail_cnt = 3'd5;
    run_word(8'hA7, 8'h38, 1, 1, 0);
    do_stop(0);

    repeat (5) @(negedge clk);
    chk(exp_rx_q.size() == 0, "R8 all words completed", exp_rx_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule